// File: doc/BRIEF.md
# Power-Saving Mode Controller

This block sequences the two low-power states of a small 8-bit microcontroller core. Software writes a two-bit power-control field. Bit 0 requests a light sleep, here called idle. Bit 1 requests a deep sleep, here called power-down. From the held bits the block derives three enables: one for the CPU clock, one for the peripheral clock and one for the crystal oscillator. It also reports the current mode on a two-bit status output.

Idle stops only the CPU. Timers, the serial unit and interrupt logic keep their clock, and any enabled interrupt request wakes the core by clearing the idle bit in hardware. Power-down stops the oscillator and everything behind it, and only a qualified reset brings the core back. A reset counts only after the reset pin has stayed high across a set number of machine-cycle ticks while the oscillator runs. Raising the pin during power-down restarts the oscillator so that the ticks can be counted.

In both sleep states the block overrides the external address-latch and program-read strobe levels. It also tells the pad logic whether the multiplexed low address/data port floats and whether the high address port keeps driving the address. While a reset that will end idle is still being qualified, it blocks writes to on-chip RAM.

Top module: `pwr_mode_ctl`

## Requirements
- R1: A write of 01 (bit 0 set, bit 1 clear) in run mode enters idle. Idle reads mode = 01, cpu_clk_en = 0, per_clk_en = 1 and osc_en = 1.
- R2: A write of 10 in run mode enters power-down. Power-down reads mode = 10 with cpu_clk_en, per_clk_en and osc_en all 0 while rst_pin is low. A write of 00 keeps run mode (mode = 00, all three enables 1).
- R3: A write of 11 in run mode enters power-down. Power-down takes priority over idle.
- R4: An irq pulse in idle returns the block to run mode on the next cycle. An irq pulse in run mode leaves the mode unchanged.
- R5: In power-down, irq has no effect on the mode. Raising rst_pin sets osc_en to 1 at once.
- R6: A reset is accepted only once rst_pin has stayed high over RST_TICKS (default 2) machine-cycle ticks with the oscillator enabled. An accepted reset asserts cpu_rst and leaves run mode with both control bits clear. A shorter pulse leaves the mode unchanged.
- R7: strobe_force is 1 in idle and power-down and 0 in run mode. The forced levels are ale_lvl = psen_lvl = 1 in idle and ale_lvl = psen_lvl = 0 in power-down.
- R8: p0_float is 1 in either sleep mode when ext_prog = 1. p2_addr is 1 only in idle with ext_prog = 1. Both are 0 in every other case.
- R9: ram_wr_block is 1 while the block is in idle with rst_pin high, and 0 once the reset has been accepted or the pin falls.
- R10: Control writes are ignored outside run mode. A write of 10 during idle keeps idle, and a write of 00 during power-down keeps power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| mc_tick | input | 1 | One-clock pulse per machine cycle |
| rst_pin | input | 1 | External reset pin, active high |
| irq | input | 1 | Enabled interrupt request |
| wr_en | input | 1 | Power-control write strobe |
| wr_data | input | 2 | Write data: bit 0 idle, bit 1 power-down |
| ext_prog | input | 1 | Core executes from external program memory |
| mode | output | 2 | 00 run, 01 idle, 10 power-down |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| cpu_rst | output | 1 | Qualified reset to the core |
| strobe_force | output | 1 | Strobe pins take the forced levels |
| ale_lvl | output | 1 | Forced address-latch strobe level |
| psen_lvl | output | 1 | Forced program-read strobe level |
| p0_float | output | 1 | Low address/data port floats |
| p2_addr | output | 1 | High address port keeps the address |
| ram_wr_block | output | 1 | Inhibit on-chip RAM writes |

## Verification
The assertions check on every cycle that the mode code stays legal and that the run-mode clock enables are consistent. They also check the forced strobe levels in power-down, the power-down priority on a combined write, the interrupt wake from idle, and that power-down persists while rst_pin is low. Other behaviours need the bench's scenarios. These are the length of reset qualification in ticks, a short reset pulse during idle that leaves the mode and gates RAM writes, ignored writes in sleep, and the port-float outputs under both program-memory sources. The bench sweeps every write code against both values of ext_prog.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int RST_TICKS = 2
) (
  input  logic       clk,
  input  logic       mc_tick,
  input  logic       rst_pin,
  input  logic       irq,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  input  logic       ext_prog,
  output logic [1:0] mode,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic       cpu_rst,
  output logic       strobe_force,
  output logic       ale_lvl,
  output logic       psen_lvl,
  output logic       p0_float,
  output logic       p2_addr,
  output logic       ram_wr_block
);
  localparam int CW = $clog2(RST_TICKS + 1);
  localparam logic [1:0] M_RUN = 2'b00, M_IDLE = 2'b01, M_PD = 2'b10;

  logic [CW-1:0] rcnt;
  logic idl_q, pd_q;
  logic in_run, in_idle, in_pd;

  assign mode    = pd_q ? M_PD : (idl_q ? M_IDLE : M_RUN);
  assign in_run  = (mode == M_RUN);
  assign in_idle = (mode == M_IDLE);
  assign in_pd   = (mode == M_PD);

  assign cpu_rst = (rcnt == CW'(RST_TICKS));

  always_ff @(posedge clk) begin
    if (!rst_pin)
      rcnt <= '0;
    else if (mc_tick && osc_en && !cpu_rst)
      rcnt <= rcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (cpu_rst) begin
      idl_q <= 1'b0;
      pd_q  <= 1'b0;
    end else if (in_run && wr_en) begin
      idl_q <= wr_data[0];
      pd_q  <= wr_data[1];
    end else if (in_idle && irq) begin
      idl_q <= 1'b0;
    end
  end

  assign cpu_clk_en   = in_run;
  assign per_clk_en   = !in_pd;
  assign osc_en       = !in_pd || rst_pin;
  assign strobe_force = !in_run;
  assign ale_lvl      = in_idle;
  assign psen_lvl     = in_idle;
  assign p0_float     = !in_run && ext_prog;
  assign p2_addr      = in_idle && ext_prog;
  assign ram_wr_block = in_idle && rst_pin;
endmodule

module pwr_mode_ctl_chk (
  input logic       clk,
  input logic       rst_pin,
  input logic       irq,
  input logic       wr_en,
  input logic [1:0] wr_data,
  input logic [1:0] mode,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       osc_en,
  input logic       cpu_rst,
  input logic       strobe_force,
  input logic       ale_lvl,
  input logic       psen_lvl
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (cpu_rst) armed <= 1'b1;

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!armed)
    mode != 2'b11); // R2
  AST_RUN_CLOCKS: assert property (@(posedge clk) disable iff (!armed)
    mode == 2'b00 |-> cpu_clk_en && per_clk_en && osc_en); // R2
  AST_PD_PRIORITY: assert property (@(posedge clk) disable iff (!armed)
    mode == 2'b00 && wr_en && wr_data == 2'b11 && !rst_pin |=> mode == 2'b10); // R3
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!armed)
    mode == 2'b01 && irq && !rst_pin |=> mode == 2'b00); // R4
  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!armed)
    mode == 2'b10 && !rst_pin |=> mode == 2'b10); // R5
  AST_PD_STROBES: assert property (@(posedge clk) disable iff (!armed)
    mode == 2'b10 |-> strobe_force && !ale_lvl && !psen_lvl); // R7
  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!armed)
    mode == 2'b01 |-> strobe_force && ale_lvl && psen_lvl && !cpu_clk_en); // R7
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk u_chk (
  .clk(clk), .rst_pin(rst_pin), .irq(irq), .wr_en(wr_en), .wr_data(wr_data),
  .mode(mode), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
  .cpu_rst(cpu_rst), .strobe_force(strobe_force), .ale_lvl(ale_lvl), .psen_lvl(psen_lvl)
);

// File: tb/test_pwr_mode_ctl.sv
module test_pwr_mode_ctl;
  logic clk = 0, mc_tick = 0, rst_pin = 0, irq = 0, wr_en = 0, ext_prog = 0;
  logic [1:0] wr_data = 0;
  logic [1:0] mode;
  logic cpu_clk_en, per_clk_en, osc_en, cpu_rst, strobe_force, ale_lvl, psen_lvl;
  logic p0_float, p2_addr, ram_wr_block;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctl i_pwr_mode_ctl (.*);

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      mc_tick = (k % 4 == 0);
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(bit in_pd);
    @(negedge clk); rst_pin = 1;
    #1 if (in_pd) chk("R5 osc_en restarts with rst_pin", osc_en, 1);
    clocks(14);
    chk("R6 cpu_rst after qualified pulse", cpu_rst, 1);
    rst_pin = 0;
    clocks(2);
    chk("R6 run after reset", mode, 0);
    chk("R6 cpu_rst released", cpu_rst, 0);
  endtask

  task automatic wr(logic [1:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_irq();
    irq = 1; @(negedge clk); irq = 0;
  endtask

  initial begin
    clocks(3);
    do_reset(0);
    chk("R2 run cpu_clk_en", cpu_clk_en, 1);
    chk("R7 run strobe_force", strobe_force, 0);

    for (int d = 0; d < 4; d++) begin
      for (int ep = 0; ep < 2; ep++) begin
        int em;
        do_reset(mode == 2);
        ext_prog = ep[0];
        @(negedge clk);
        wr(d[1:0]);
        em = d[1] ? 2 : (d[0] ? 1 : 0);
        chk(d == 3 ? "R3 both bits -> pd" : "R1/R2 mode after write", mode, em);
        chk("R1/R2 cpu_clk_en", cpu_clk_en, em == 0);
        chk("R1/R2 per_clk_en", per_clk_en, em != 2);
        chk("R1/R2 osc_en", osc_en, em != 2);
        chk("R7 strobe_force", strobe_force, em != 0);
        if (em != 0) chk("R7 ale level", ale_lvl, em == 1);
        if (em != 0) chk("R7 psen level", psen_lvl, em == 1);
        chk("R8 p0_float", p0_float, (em != 0) && ep == 1);
        chk("R8 p2_addr", p2_addr, (em == 1) && ep == 1);
        pulse_irq();
        chk(em == 2 ? "R5 irq ignored in pd" : "R4 irq wakes idle / no effect in run",
            mode, em == 2 ? 2 : 0);
      end
    end
    ext_prog = 0;

    do_reset(1);
    wr(2'b01);
    wr(2'b10);
    chk("R10 write ignored in idle", mode, 1);
    @(negedge clk); rst_pin = 1;
    #1 chk("R9 ram_wr_block during reset in idle", ram_wr_block, 1);
    @(negedge clk); rst_pin = 0;
    @(negedge clk);
    chk("R6 short pulse keeps idle", mode, 1);
    chk("R9 ram_wr_block after pin falls", ram_wr_block, 0);
    @(negedge clk); rst_pin = 1;
    clocks(14);
    chk("R9 ram_wr_block after accept", ram_wr_block, 0);
    rst_pin = 0; clocks(2);
    chk("R6 idle ended by reset", mode, 0);

    wr(2'b10);
    wr(2'b00);
    chk("R10 write ignored in pd", mode, 2);
    pulse_irq();
    chk("R5 pd kept after irq", mode, 2);
    do_reset(1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule